// File: doc/BRIEF.md
# Serial Peripheral Master with Word Bursts and Hardware Select

This block is a synchronous serial master that shifts out words of 1 to 32 bits on a clock it divides from the system clock. The data comes from two transmit word inputs and lands in two receive word outputs. Software sets the word length, the clock polarity and phase, and the divider. It then pulses `start`. The block asserts a slave select, runs the serial clock for the whole transfer, releases the select and raises a sticky `done` flag that software clears with `done_clr`.

A transfer carries one word or, in burst mode, two words back to back (word 0 first, up to 64 bits in all). A dual-lane mode moves two bits per serial clock: lane 0 carries word 0 and lane 1 carries word 1. The two select outputs can follow each transfer automatically, for the lines picked in `ss_sel`, or they can be held by software through `ss_man`. In both cases the active level is programmable.

Top module: `spi_burst_master`

## Requirements
- R1: After reset `busy` and `done` are 0, `sclk` equals `cpol` and, in automatic select mode, both `ss` lines sit at the inactive level (`~ss_lvl`).
- R2: Each half period of `sclk` lasts `divider`+1 system clocks, and a `divider` of 0 acts as 1. `busy` is high for (2·N+2)·(`divider`+1) clocks, where N is the number of serial clocks in the transfer.
- R3: `word_len` values 1 to 31 give that many bits, and 0 gives 32 bits. Bits go out MSB first from bit `word_len`-1. Received bits are shifted in at the LSB of the receive word, so each received word is right-justified, and `rx0`/`rx1` are cleared at start.
- R4: With `burst`=1 (and `dual`=0) a transfer sends `tx0` and then `tx1` on `mosi[0]`, 2·L bits in all. The first L bits received fill `rx0` and the next L bits fill `rx1`. With `burst`=0 only word 0 moves and `rx1` reads 0.
- R5: When idle, `sclk` rests at `cpol`. With `cpha`=0 both sides sample on the leading (first) edge of each clock and data changes on the trailing edge. With `cpha`=1 data changes on the leading edge and both sides sample on the trailing edge.
- R6: With `dual`=1 each serial clock carries `tx0` on `mosi[0]` and `tx1` on `mosi[1]`. `miso[0]` fills `rx0` and `miso[1]` fills `rx1`, L clocks in all, and `burst` is ignored. With `dual`=0, `mosi[1]` stays 0.
- R7: With `auto_ss`=1, each line whose `ss_sel` bit is 1 goes to `ss_lvl` from the cycle after `start` until `busy` falls. Lines that are not selected, and all lines while idle, stay at `~ss_lvl`.
- R8: With `auto_ss`=0, `ss[i]` equals `ss_lvl` when `ss_man[i]` is 1 and `~ss_lvl` otherwise, and transfers do not change it.
- R9: `done` rises in the same cycle that `busy` falls. It stays 1 until a `done_clr` pulse, and a set in the same cycle as a clear wins.
- R10: A `start` while `busy` is 1 is ignored: the transfer in progress keeps its length and its data. The transmit inputs and the other fields are captured only at an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transfer request |
| divider | input | 16 | Half-period divider (0 acts as 1) |
| word_len | input | 5 | Bits per word, 0 means 32 |
| burst | input | 1 | 1: two words per transfer |
| dual | input | 1 | 1: two data lanes, single word |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| auto_ss | input | 1 | 1: hardware-timed select, 0: manual |
| ss_sel | input | 2 | Lines driven in automatic mode |
| ss_man | input | 2 | Lines asserted in manual mode |
| ss_lvl | input | 1 | Active level of the select lines |
| tx0 | input | 32 | Transmit word 0 |
| tx1 | input | 32 | Transmit word 1 |
| done_clr | input | 1 | Clears done |
| rx0 | output | 32 | Receive word 0 |
| rx1 | output | 32 | Receive word 1 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky transfer-complete flag |
| sclk | output | 1 | Serial clock |
| ss | output | 2 | Slave select lines |
| mosi | output | 2 | Serial data out, lanes 0 and 1 |
| miso | input | 2 | Serial data in, lanes 0 and 1 |

## Verification
The select and idle-clock properties read `cpol`, `ss_sel` and `ss_lvl` live rather than as captured copies. They therefore assume those fields are not changed while `busy` is high. The bench programs every field before it pulses `start` and leaves them alone until `busy` falls. The one deliberate change under `busy` is a second `start` with new transmit words, and that exercises R10. The bench slave model samples and drives only on `sclk` edges, following the selected phase, so the received data depends only on the legal edge order.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DIV_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [DIV_W-1:0]          divider,
  input  logic [$clog2(WORD_W)-1:0] word_len,
  input  logic                      burst,
  input  logic                      dual,
  input  logic                      cpol,
  input  logic                      cpha,
  input  logic                      auto_ss,
  input  logic [1:0]                ss_sel,
  input  logic [1:0]                ss_man,
  input  logic                      ss_lvl,
  input  logic [WORD_W-1:0]         tx0,
  input  logic [WORD_W-1:0]         tx1,
  input  logic                      done_clr,
  output logic [WORD_W-1:0]         rx0,
  output logic [WORD_W-1:0]         rx1,
  output logic                      busy,
  output logic                      done,
  output logic                      sclk,
  output logic [1:0]                ss,
  output logic [1:0]                mosi,
  input  logic [1:0]                miso
);
  localparam int LEN_W = $clog2(WORD_W);
  localparam int CNT_W = $clog2(4*WORD_W+1);
  localparam logic [1:0] S_IDLE = 2'd0, S_SETUP = 2'd1, S_RUN = 2'd2, S_HOLD = 2'd3;

  logic [1:0]        st;
  logic [DIV_W-1:0]  hc, div_l;
  logic [LEN_W:0]    len_l;
  logic              two_l, dual_l, cpha_l, cpol_l, ph;
  logic [WORD_W-1:0] txl0, txl1;
  logic [CNT_W-1:0]  e;

  wire [LEN_W:0]   len_in = (word_len == '0) ? (LEN_W+1)'(WORD_W) : {1'b0, word_len};
  wire [DIV_W-1:0] div_in = (divider == '0) ? DIV_W'(1) : divider;

  wire             tick   = (hc == div_l);
  wire [CNT_W-1:0] len_c  = CNT_W'(len_l);
  wire [CNT_W-1:0] nbits  = len_c + (two_l ? len_c : '0);
  wire [CNT_W-1:0] nedges = nbits << 1;
  wire [CNT_W-1:0] oidx   = cpha_l ? ((e == '0) ? '0 : ((e - CNT_W'(1)) >> 1)) : (e >> 1);
  wire [CNT_W-1:0] sidx   = e >> 1;
  wire             owrd   = !dual_l && (oidx >= len_c);
  wire [CNT_W-1:0] opos   = len_c - CNT_W'(1) - oidx + (owrd ? len_c : '0);
  wire [LEN_W-1:0] obit   = opos[LEN_W-1:0];
  wire             smp    = cpha_l ? e[0] : ~e[0];
  wire             into1  = !dual_l && (sidx >= len_c);

  assign busy    = (st != S_IDLE);
  assign sclk    = busy ? (cpol_l ^ ph) : cpol;
  assign mosi[0] = owrd ? txl1[obit] : txl0[obit];
  assign mosi[1] = dual_l & txl1[obit];
  assign ss      = ~({2{ss_lvl}} ^ (auto_ss ? (ss_sel & {2{busy}}) : ss_man));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hc <= '0; div_l <= DIV_W'(1); len_l <= '0;
      two_l <= 1'b0; dual_l <= 1'b0; cpha_l <= 1'b0; cpol_l <= 1'b0; ph <= 1'b0;
      txl0 <= '0; txl1 <= '0; e <= '0; rx0 <= '0; rx1 <= '0; done <= 1'b0;
    end else begin
      if (done_clr) done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_SETUP; hc <= '0; e <= '0; ph <= 1'b0;
          div_l <= div_in; len_l <= len_in;
          two_l <= burst & ~dual; dual_l <= dual;
          cpha_l <= cpha; cpol_l <= cpol;
          txl0 <= tx0; txl1 <= tx1; rx0 <= '0; rx1 <= '0;
        end
        S_SETUP: begin
          hc <= tick ? '0 : hc + DIV_W'(1);
          if (tick) st <= S_RUN;
        end
        S_RUN: begin
          hc <= tick ? '0 : hc + DIV_W'(1);
          if (tick) begin
            ph <= ~ph;
            e  <= e + CNT_W'(1);
            if (smp) begin
              if (dual_l) begin
                rx0 <= {rx0[WORD_W-2:0], miso[0]};
                rx1 <= {rx1[WORD_W-2:0], miso[1]};
              end else if (into1) begin
                rx1 <= {rx1[WORD_W-2:0], miso[0]};
              end else begin
                rx0 <= {rx0[WORD_W-2:0], miso[0]};
              end
            end
            if (e == nedges - CNT_W'(1)) st <= S_HOLD;
          end
        end
        default: begin
          hc <= tick ? '0 : hc + DIV_W'(1);
          if (tick) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module spi_burst_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       done_clr,
  input logic       sclk,
  input logic       cpol,
  input logic       auto_ss,
  input logic       ss_lvl,
  input logic [1:0] ss
);
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol); // R5
  AST_SS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && auto_ss) |-> ss == {2{~ss_lvl}}); // R7
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R10
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done); // R9
endmodule

bind spi_burst_master spi_burst_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .done_clr(done_clr), .sclk(sclk), .cpol(cpol), .auto_ss(auto_ss),
  .ss_lvl(ss_lvl), .ss(ss)
);

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, burst = 0, dual = 0, cpol = 0, cpha = 0, auto_ss = 1, ss_lvl = 0, done_clr = 0;
  logic [15:0] divider = 16'd1;
  logic [4:0]  word_len = 5'd8;
  logic [1:0]  ss_sel = 2'b01, ss_man = 2'b00, miso;
  logic [31:0] tx0 = '0, tx1 = '0, rx0, rx1;
  logic busy, done, sclk;
  logic [1:0] ss, mosi;

  int total = 0, bad = 0;
  logic [63:0] pa = '0, pb = '0, rec0 = '0, rec1 = '0;
  int scnt = 0, edges = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_burst_master u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .divider(divider), .word_len(word_len),
    .burst(burst), .dual(dual), .cpol(cpol), .cpha(cpha), .auto_ss(auto_ss),
    .ss_sel(ss_sel), .ss_man(ss_man), .ss_lvl(ss_lvl), .tx0(tx0), .tx1(tx1),
    .done_clr(done_clr), .rx0(rx0), .rx1(rx1), .busy(busy), .done(done),
    .sclk(sclk), .ss(ss), .mosi(mosi), .miso(miso)
  );

  assign miso[0] = (scnt < 64) ? pa[63-scnt] : 1'b0;
  assign miso[1] = (scnt < 64) ? pb[63-scnt] : 1'b0;

  always @(posedge sclk or negedge sclk) begin
    if (rst_n && busy) begin
      edges = edges + 1;
      if ((sclk != cpol) == !cpha) begin
        rec0 = {rec0[62:0], mosi[0]};
        rec1 = {rec1[62:0], mosi[1]};
        scnt = scnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_ss(input logic act);
    logic [1:0] r;
    for (int i = 0; i < 2; i++) begin
      logic on;
      on = auto_ss ? (ss_sel[i] & act) : ss_man[i];
      r[i] = on ? ss_lvl : ~ss_lvl;
    end
    return r;
  endfunction

  task automatic xfer(input string req, input logic [31:0] a, input logic [31:0] b, input bit restart);
    int L, nb, dv, cyc, sserr;
    logic [63:0] e0, e1;
    logic [31:0] mask, r0e, r1e;
    L = (word_len == 0) ? 32 : int'(word_len);
    nb = dual ? L : (burst ? 2*L : L);
    dv = (divider == 0) ? 2 : int'(divider) + 1;
    @(negedge clk);
    tx0 = a; tx1 = b;
    check({req, " idle sclk level R5"}, {63'd0, sclk}, {63'd0, cpol});
    rec0 = '0; rec1 = '0; scnt = 0; edges = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; sserr = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      if (ss !== exp_ss(1'b1)) sserr++;
      if (restart && cyc == 5) begin start = 1'b1; tx0 = ~a; tx1 = ~b; end
      if (restart && cyc == 6) start = 1'b0;
      @(negedge clk);
    end
    tx0 = a; tx1 = b;
    check({req, " busy cycles R2"}, 64'(cyc), 64'((2*nb+2)*dv));
    check({req, " sclk edges R2"}, 64'(edges), 64'(2*nb));
    check({req, " select during transfer R7 R8"}, 64'(sserr), 64'd0);
    check({req, " select after transfer R7 R8"}, {62'd0, ss}, {62'd0, exp_ss(1'b0)});
    check({req, " done raised R9"}, {63'd0, done}, 64'd1);
    e0 = '0; e1 = '0;
    for (int i = 0; i < nb; i++) begin
      if (dual) begin
        e0 = {e0[62:0], a[L-1-i]};
        e1 = {e1[62:0], b[L-1-i]};
      end else if (i >= L) begin
        e0 = {e0[62:0], b[2*L-1-i]};
        e1 = {e1[62:0], 1'b0};
      end else begin
        e0 = {e0[62:0], a[L-1-i]};
        e1 = {e1[62:0], 1'b0};
      end
    end
    check({req, " mosi lane0 stream R3 R4"}, rec0, e0);
    check({req, " mosi lane1 stream R6"}, rec1, e1);
    mask = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 32'd1);
    r0e = 32'(pa >> (64 - L)) & mask;
    if (dual) r1e = 32'(pb >> (64 - L)) & mask;
    else if (burst) r1e = 32'(pa >> (64 - 2*L)) & mask;
    else r1e = '0;
    check({req, " rx0 R3"}, 64'(rx0), 64'(r0e));
    check({req, " rx1 R4 R6"}, 64'(rx1), 64'(r1e));
    @(negedge clk);
    check({req, " done sticky R9"}, {63'd0, done}, 64'd1);
    check({req, " no extra transfer R10"}, {63'd0, busy}, 64'd0);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    check({req, " done cleared R9"}, {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("reset busy R1", {63'd0, busy}, 64'd0);
    check("reset done R1", {63'd0, done}, 64'd0);
    check("reset sclk R1", {63'd0, sclk}, {63'd0, cpol});
    check("reset ss R1", {62'd0, ss}, {62'd0, {2{~ss_lvl}}});
  endtask

  task automatic t_mode0_byte();
    cpol = 0; cpha = 0; divider = 16'd1; word_len = 5'd8; burst = 0; dual = 0;
    pa = 64'hA5C3_0000_0000_0000;
    xfer("mode0 8-bit R3 R5", 32'h0000_00B6, 32'h0000_0011, 1'b0);
  endtask

  task automatic t_mode3_half();
    cpol = 1; cpha = 1; divider = 16'd3; word_len = 5'd16;
    pa = 64'h1E2D_3C4B_5A69_7887;
    xfer("mode3 16-bit R2 R5", 32'hFFFF_C0DE, 32'h0, 1'b0);
  endtask

  task automatic t_burst32();
    cpol = 0; cpha = 1; divider = 16'd2; word_len = 5'd0; burst = 1;
    pa = 64'hDEAD_BEEF_0123_4567;
    xfer("mode1 32-bit burst R3 R4", 32'h8765_4321, 32'h0F0F_A5A5, 1'b0);
  endtask

  task automatic t_burst5_div0();
    cpol = 1; cpha = 0; divider = 16'd0; word_len = 5'd5; burst = 1;
    pa = 64'hB7C0_0000_0000_0000;
    xfer("mode2 5-bit burst div0 R2 R4", 32'hFFFF_FFF6, 32'h0000_0013, 1'b0);
  endtask

  task automatic t_dual();
    cpol = 0; cpha = 0; divider = 16'd1; word_len = 5'd12; burst = 1; dual = 1;
    pa = 64'h9AB0_0000_0000_0000; pb = 64'h3570_0000_0000_0000;
    xfer("dual 12-bit R6", 32'h0000_0ABC, 32'h0000_0531, 1'b0);
    dual = 0; burst = 0;
  endtask

  task automatic t_manual();
    auto_ss = 0; ss_man = 2'b10; ss_lvl = 1; word_len = 5'd7;
    pa = 64'h5500_0000_0000_0000;
    xfer("manual select R8", 32'h0000_0049, 32'h0, 1'b0);
    auto_ss = 1; ss_man = 2'b00;
  endtask

  task automatic t_auto_hi();
    auto_ss = 1; ss_sel = 2'b10; ss_lvl = 1; word_len = 5'd9; cpha = 1;
    pa = 64'hE380_0000_0000_0000;
    xfer("auto select line1 active-high R7", 32'h0000_01A3, 32'h0, 1'b0);
    ss_sel = 2'b01; ss_lvl = 0;
  endtask

  task automatic t_restart();
    cpol = 0; cpha = 0; divider = 16'd2; word_len = 5'd10; burst = 1;
    pa = 64'h6C3F_0A00_0000_0000;
    xfer("start while busy R10", 32'h0000_02D1, 32'h0000_0147, 1'b1);
    burst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mode0_byte();
    t_mode3_half();
    t_burst32();
    t_burst5_div0();
    t_dual();
    t_manual();
    t_auto_hi();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule